// File: doc/BRIEF.md
# Jittered Fixed-Frequency PWM Core

This block is the digital timing core of a current-mode switching controller. A cycle counter launches each switching period: the gate command goes high when the period begins. It goes low when the external current comparator trips, or when the on-time reaches 80% of the period, whichever comes first. Comparator trips that arrive within a fixed blanking window after turn-on are ignored, so the switching spike at the leading edge cannot end the pulse.

For electromagnetic spreading, the period length moves along a triangle around its nominal value. At each period start, the offset that the new period uses is taken and then stepped by one clock cycle every few periods. The offset reverses direction at plus and minus the configured limit. With a 50 MHz clock, the defaults give a 65 kHz or a 100 kHz nominal rate, each swept by about ±7.5% over a sweep of roughly 6 to 7 ms. The block also drives a window output for an external compensation-ramp generator, and a one-cycle period-start strobe.

Top module: `pwm_jit_core`

## Requirements
- R1: While reset is asserted or `enable` is low, `gateOut`, `periodStart` and `rampSync` are all low.
- R2: `periodStart` is high for exactly one cycle, the first cycle of each switching period, and `gateOut` is high in that cycle.
- R3: `freqSel` = 0 selects the nominal period NOM_SLOW and `freqSel` = 1 selects NOM_FAST. It is sampled only at the edge that starts a period and applies to that period.
- R4: Period k lasts nominal + o(k) cycles. o(0) = 0 after reset, and the direction starts upward. After each period start, a hold count advances. Once it has reached HOLD−1 of the option just loaded, o moves one step in the current direction and the count clears. The direction turns down when o reaches +JIT, and turns up when o reaches −JIT.
- R5: Without a trip, `gateOut` stays high for floor(4·P/5) cycles of a period of P cycles, and never for longer.
- R6: A trip sampled at the clock edge that ends cycle index k of the period (k ≥ BLANK_CYC, index 0 is the first cycle) ends the pulse after k+1 cycles. The gate then stays low until the next period start.
- R7: Trips sampled at cycle indices below BLANK_CYC have no effect. A trip held from index 0 ends the pulse after BLANK_CYC+1 cycles.
- R8: `rampSync` is high for the first floor(4·P/5) cycles of every period and low for the rest.
- R9: When `enable` falls, `gateOut` drops in the same cycle, even in the middle of a pulse. When `enable` is sampled high again, the next cycle starts a fresh period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz by default) |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run control; low holds the core idle with the gate off |
| freqSel | input | 1 | Nominal rate option: 0 slow, 1 fast |
| csTrip | input | 1 | Current-sense comparator trip |
| gateOut | output | 1 | Gate drive command |
| periodStart | output | 1 | One-cycle strobe in the first cycle of each period |
| rampSync | output | 1 | High during the 80% window of each period for the compensation ramp |

## Verification
Consecutive periods are run with no trip, with a trip after the blanking window, and with a trip held from inside the window or from index zero. These cases separate cycle-by-cycle termination, blanking and the duty clamp. A trip placed beyond the clamp point shows that the clamp wins. Measuring each period length across many cycles, and across a switch between the two rate options, separates the nominal selection from the triangle sweep, including the reversals at both bounds and the hold of several periods per step. A drop of `enable` in the middle of a pulse, followed by a restart, shows the immediate gate cut-off and the fresh period start.

// File: rtl/pwm_jit_pkg.sv
package pwm_jit_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic loadPeriod;  // start a new switching period
    logic holdIdle;    // park the counter
  } ctlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic isZero;      // first cycle of a period
    logic atLast;      // final cycle of the period
    logic pastBlank;   // blanking window elapsed
    logic atLimitEnd;  // final cycle allowed for the on-time
    logic inRamp;      // inside the 80% window
  } dpStatus_t;

endpackage

// File: rtl/pwm_jit_datapath.sv
module pwm_jit_datapath
  import pwm_jit_pkg::*;
#(
  parameter int NOM_SLOW  = 769,
  parameter int NOM_FAST  = 500,
  parameter int JIT_SLOW  = 57,
  parameter int JIT_FAST  = 37,
  parameter int HOLD_SLOW = 2,
  parameter int HOLD_FAST = 4,
  parameter int BLANK_CYC = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       freqSel,
  input  ctlStrobe_t ctl,
  output dpStatus_t  status
);

  localparam int MAXP = ((NOM_SLOW + JIT_SLOW) > (NOM_FAST + JIT_FAST)) ?
                        (NOM_SLOW + JIT_SLOW) : (NOM_FAST + JIT_FAST);
  localparam int MAXJ = (JIT_SLOW > JIT_FAST) ? JIT_SLOW : JIT_FAST;
  localparam int MAXH = (HOLD_SLOW > HOLD_FAST) ? HOLD_SLOW : HOLD_FAST;
  localparam int PW   = $clog2(MAXP + 1);
  localparam int LW   = PW + 3;
  localparam int OW   = $clog2(MAXJ + 1) + 1;
  localparam int HW   = $clog2(MAXH + 1);

  logic [PW-1:0]        cnt;
  logic [PW-1:0]        curPeriod;
  logic [PW-1:0]        curLimit;
  logic signed [OW-1:0] offset;
  logic                 dirUp;
  logic [HW-1:0]        holdCnt;

  logic [PW-1:0]        nomSel;
  logic signed [OW-1:0] jitLim;
  logic [HW-1:0]        holdSel;
  logic signed [PW:0]   sumP;
  logic [PW-1:0]        nextPeriod;
  logic [LW-1:0]        scaled;
  logic [PW-1:0]        nextLimit;
  logic signed [OW-1:0] stepOff;
  logic                 holdDone;

  // option selection for the period about to be loaded
  assign nomSel  = freqSel ? PW'(NOM_FAST)  : PW'(NOM_SLOW);
  assign jitLim  = freqSel ? OW'(JIT_FAST)  : OW'(JIT_SLOW);
  assign holdSel = freqSel ? HW'(HOLD_FAST) : HW'(HOLD_SLOW);

  // jittered period and its 80% on-time limit
  assign sumP       = $signed({1'b0, nomSel}) +
                      $signed({{(PW + 1 - OW){offset[OW-1]}}, offset});
  assign nextPeriod = PW'(sumP);
  assign scaled     = {1'b0, nextPeriod, 2'b00};
  assign nextLimit  = PW'(scaled / LW'(5));

  // triangle sweep step
  assign stepOff  = dirUp ? (offset + OW'(1)) : (offset - OW'(1));
  assign holdDone = (holdCnt >= (holdSel - HW'(1)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= '0;
      curPeriod <= PW'(NOM_SLOW);
      curLimit  <= PW'((NOM_SLOW * 4) / 5);
      offset    <= '0;
      dirUp     <= 1'b1;
      holdCnt   <= '0;
    end else if (ctl.holdIdle) begin
      cnt <= '0;
    end else if (ctl.loadPeriod) begin
      cnt       <= '0;
      curPeriod <= nextPeriod;
      curLimit  <= nextLimit;
      if (holdDone) begin
        holdCnt <= '0;
        offset  <= stepOff;
        if (stepOff >= jitLim)       dirUp <= 1'b0;
        else if (stepOff <= -jitLim) dirUp <= 1'b1;
      end else begin
        holdCnt <= holdCnt + HW'(1);
      end
    end else begin
      cnt <= cnt + PW'(1);
    end
  end

  assign status.isZero     = (cnt == '0);
  assign status.atLast     = (cnt == (curPeriod - PW'(1)));
  assign status.pastBlank  = (cnt >= PW'(BLANK_CYC));
  assign status.atLimitEnd = (cnt == (curLimit - PW'(1)));
  assign status.inRamp     = (cnt < curLimit);

endmodule

// File: rtl/pwm_jit_control.sv
module pwm_jit_control
  import pwm_jit_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       csTrip,
  input  dpStatus_t  status,
  output ctlStrobe_t ctl,
  output logic       gateOut,
  output logic       periodStart,
  output logic       rampSync
);

  logic started;
  logic pulseOn;
  logic tripHit;

  assign ctl.holdIdle   = !enable;
  assign ctl.loadPeriod = enable && (!started || status.atLast);

  // a trip counts only once the blanking window is over
  assign tripHit = csTrip && status.pastBlank;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      started <= 1'b0;
      pulseOn <= 1'b0;
    end else if (!enable) begin
      started <= 1'b0;
      pulseOn <= 1'b0;
    end else if (ctl.loadPeriod) begin
      started <= 1'b1;
      pulseOn <= 1'b1;
    end else if (pulseOn && (tripHit || status.atLimitEnd)) begin
      pulseOn <= 1'b0;
    end
  end

  assign gateOut     = enable && pulseOn;
  assign periodStart = enable && started && status.isZero;
  assign rampSync    = enable && started && status.inRamp;

endmodule

// File: rtl/pwm_jit_core.sv
module pwm_jit_core
  import pwm_jit_pkg::*;
#(
  parameter int NOM_SLOW  = 769,
  parameter int NOM_FAST  = 500,
  parameter int JIT_SLOW  = 57,
  parameter int JIT_FAST  = 37,
  parameter int HOLD_SLOW = 2,
  parameter int HOLD_FAST = 4,
  parameter int BLANK_CYC = 9
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic freqSel,
  input  logic csTrip,
  output logic gateOut,
  output logic periodStart,
  output logic rampSync
);

  ctlStrobe_t ctl;
  dpStatus_t  status;

  pwm_jit_datapath #(
    .NOM_SLOW (NOM_SLOW),
    .NOM_FAST (NOM_FAST),
    .JIT_SLOW (JIT_SLOW),
    .JIT_FAST (JIT_FAST),
    .HOLD_SLOW(HOLD_SLOW),
    .HOLD_FAST(HOLD_FAST),
    .BLANK_CYC(BLANK_CYC)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .freqSel(freqSel),
    .ctl    (ctl),
    .status (status)
  );

  pwm_jit_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .csTrip     (csTrip),
    .status     (status),
    .ctl        (ctl),
    .gateOut    (gateOut),
    .periodStart(periodStart),
    .rampSync   (rampSync)
  );

endmodule

// File: rtl/pwm_jit_checker.sv
module pwm_jit_checker #(
  parameter int NOM_SLOW = 769,
  parameter int NOM_FAST = 500,
  parameter int JIT_SLOW = 57,
  parameter int JIT_FAST = 37
) (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic gateOut,
  input logic periodStart,
  input logic rampSync
);

  localparam int MINP = ((NOM_SLOW - JIT_SLOW) < (NOM_FAST - JIT_FAST)) ?
                        (NOM_SLOW - JIT_SLOW) : (NOM_FAST - JIT_FAST);
  localparam int MAXP = ((NOM_SLOW + JIT_SLOW) > (NOM_FAST + JIT_FAST)) ?
                        (NOM_SLOW + JIT_SLOW) : (NOM_FAST + JIT_FAST);
  localparam int CW   = $clog2(MAXP + 2) + 1;

  logic [CW-1:0] lenCnt;
  logic          seenStart;

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      lenCnt    <= '0;
      seenStart <= 1'b0;
    end else if (periodStart) begin
      lenCnt    <= CW'(1);
      seenStart <= 1'b1;
    end else if (lenCnt != '1) begin
      lenCnt <= lenCnt + CW'(1);
    end
  end

  assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (!gateOut && !periodStart && !rampSync));

  assert_start_gate_R2: assert property (@(posedge clk) disable iff (!rstN)
    periodStart |-> gateOut);

  assert_start_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    periodStart |=> !periodStart);

  assert_period_bounds_R4: assert property (@(posedge clk) disable iff (!rstN)
    (periodStart && seenStart) |-> (lenCnt >= CW'(MINP) && lenCnt <= CW'(MAXP)));

  assert_clamp_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    gateOut |-> rampSync);

  assert_no_reopen_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!gateOut && !periodStart) |=> (!gateOut || periodStart));

  assert_blank_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    periodStart |=> (!enable || gateOut));

  assert_ramp_from_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    periodStart |-> rampSync);

endmodule

bind pwm_jit_core pwm_jit_checker #(
  .NOM_SLOW(NOM_SLOW),
  .NOM_FAST(NOM_FAST),
  .JIT_SLOW(JIT_SLOW),
  .JIT_FAST(JIT_FAST)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .enable     (enable),
  .gateOut    (gateOut),
  .periodStart(periodStart),
  .rampSync   (rampSync)
);

// File: tb/pwm_jit_core_tb.sv
module pwm_jit_core_tb;

  localparam int CLK_PERIOD = 20;
  localparam int NOM_SLOW   = 40;
  localparam int NOM_FAST   = 26;
  localparam int JIT_SLOW   = 3;
  localparam int JIT_FAST   = 2;
  localparam int HOLD_SLOW  = 1;
  localparam int HOLD_FAST  = 2;
  localparam int BLANK_CYC  = 4;
  localparam int NOTRIP     = 255;
  localparam int NVEC       = 22;

  // {freqSel for this period (applies from the next one), trip index}
  localparam logic [8:0] VEC [0:NVEC-1] = '{
    {1'b0, 8'd255}, {1'b0, 8'd10},  {1'b0, 8'd2},   {1'b0, 8'd4},
    {1'b0, 8'd0},   {1'b0, 8'd255}, {1'b0, 8'd33},  {1'b0, 8'd20},
    {1'b0, 8'd255}, {1'b0, 8'd3},   {1'b0, 8'd255}, {1'b1, 8'd255},
    {1'b1, 8'd8},   {1'b1, 8'd255}, {1'b1, 8'd1},   {1'b1, 8'd15},
    {1'b1, 8'd255}, {1'b1, 8'd255}, {1'b1, 8'd30},  {1'b0, 8'd5},
    {1'b0, 8'd255}, {1'b0, 8'd255}
  };

  logic clk = 1'b0;
  logic rstN, enable, freqSel, csTrip;
  logic gateOut, periodStart, rampSync;

  int checks = 0;
  int fails  = 0;

  // reference sweep state
  int mOff = 0, mUp = 1, mHold = 0, mSel = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_jit_core #(
    .NOM_SLOW(NOM_SLOW), .NOM_FAST(NOM_FAST),
    .JIT_SLOW(JIT_SLOW), .JIT_FAST(JIT_FAST),
    .HOLD_SLOW(HOLD_SLOW), .HOLD_FAST(HOLD_FAST),
    .BLANK_CYC(BLANK_CYC)
  ) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .freqSel(freqSel),
    .csTrip(csTrip), .gateOut(gateOut), .periodStart(periodStart),
    .rampSync(rampSync)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int nomOf(input int s);
    return s ? NOM_FAST : NOM_SLOW;
  endfunction
  function automatic int jitOf(input int s);
    return s ? JIT_FAST : JIT_SLOW;
  endfunction
  function automatic int holdOf(input int s);
    return s ? HOLD_FAST : HOLD_SLOW;
  endfunction

  // R4 sweep rule applied after a period of option s was started
  task automatic modelStep(input int s);
    if (mHold >= holdOf(s) - 1) begin
      mHold = 0;
      mOff  = mUp ? mOff + 1 : mOff - 1;
      if (mOff >= jitOf(s))       mUp = 0;
      else if (mOff <= -jitOf(s)) mUp = 1;
    end else begin
      mHold++;
    end
  endtask

  // entered at the falling edge inside cycle 0 of a period
  task automatic runPeriod(input int tripAt, output int plen, output int gcnt,
                           output int rcnt, output int firstGate);
    plen = 0; gcnt = 0; rcnt = 0; firstGate = gateOut;
    for (int i = 0; i < 400; i++) begin
      if (i > 0 && periodStart) begin
        plen = i;
        break;
      end
      gcnt += int'(gateOut);
      rcnt += int'(rampSync);
      csTrip = (i >= tripAt);
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog R1..: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int plen, gcnt, rcnt, g0, p, lim, expG, k, sel, trip, opt;
    string tag;
    rstN = 1'b0; enable = 1'b0; freqSel = 1'b0; csTrip = 1'b0;
    repeat (3) @(negedge clk);
    check(!gateOut && !periodStart && !rampSync, "R1", "outputs in reset",
          {gateOut, periodStart, rampSync}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!gateOut && !periodStart && !rampSync, "R1", "outputs while disabled",
          {gateOut, periodStart, rampSync}, 0);

    enable = 1'b1;
    @(negedge clk);
    check(periodStart == 1'b1, "R9", "start after enable", periodStart, 1);
    check(gateOut == 1'b1, "R2", "gate in first cycle", gateOut, 1);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      sel  = int'(VEC[v][8]);
      trip = int'(VEC[v][7:0]);
      opt  = mSel;
      p    = nomOf(opt) + mOff;
      lim  = (p * 4) / 5;
      if (trip == NOTRIP) expG = lim;
      else begin
        k    = (trip > BLANK_CYC) ? trip : BLANK_CYC;
        expG = (k + 1 < lim) ? k + 1 : lim;
      end
      if (trip == NOTRIP || expG == lim) tag = "R5";
      else if (trip < BLANK_CYC)         tag = "R7";
      else                               tag = "R6";
      freqSel = sel[0];
      runPeriod(trip, plen, gcnt, rcnt, g0);
      check(plen == p, opt ? "R3 R4" : "R4", "period length", plen, p);
      check(gcnt == expG, tag, "gate high cycles", gcnt, expG);
      check(rcnt == lim, "R8", "ramp window cycles", rcnt, lim);
      check(g0 == 1, "R2", "gate at period start", g0, 1);
      modelStep(opt);
      mSel = sel;
    end

    // directed: enable drop mid-pulse, idle, restart
    csTrip = 1'b0;
    opt = mSel;
    modelStep(opt);            // the period now running has consumed a step
    repeat (6) @(negedge clk);
    check(gateOut == 1'b1, "R5", "gate still on mid-pulse", gateOut, 1);
    enable = 1'b0;
    #1;
    check(gateOut == 1'b0, "R9", "gate cut in same cycle", gateOut, 0);
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      check(!gateOut && !periodStart && !rampSync, "R1", "idle outputs",
            {gateOut, periodStart, rampSync}, 0);
    end
    enable = 1'b1;
    @(negedge clk);
    check(periodStart == 1'b1, "R9", "restart strobe", periodStart, 1);
    check(gateOut == 1'b1, "R9", "restart gate", gateOut, 1);

    // trip held from index 0 across the blanking window
    p   = nomOf(opt) + mOff;
    lim = (p * 4) / 5;
    runPeriod(0, plen, gcnt, rcnt, g0);
    check(gcnt == BLANK_CYC + 1, "R7", "held trip after blanking", gcnt, BLANK_CYC + 1);
    check(plen == p, "R4", "period after restart", plen, p);
    check(rcnt == lim, "R8", "ramp after restart", rcnt, lim);

    // trip exactly at the blanking boundary
    csTrip = 1'b0;
    modelStep(opt);
    p = nomOf(opt) + mOff;
    runPeriod(BLANK_CYC, plen, gcnt, rcnt, g0);
    check(gcnt == BLANK_CYC + 1, "R6", "trip at blanking edge", gcnt, BLANK_CYC + 1);
    check(plen == p, "R4", "period length", plen, p);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule